// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives three half-bridge phases. Each phase has a positive output and an inverse output. The block never delays edges to make the dead time. Instead it runs two triangle counters that are locked together and offset by the dead-time count. The leading counter sweeps from the dead-time value up to the half-carrier count plus the dead time, and back down. The lagging counter sweeps from zero up to the half-carrier count, and back down.

A phase's positive output switches when the lagging counter arrives at that phase's duty value. Its inverse output switches when the leading counter arrives at the same value. Because the two counters are offset, the two outputs of a phase are never active at the same time near a switching edge.

The block has three further outputs:
- a level that toggles at every half carrier,
- a one-clock crest pulse,
- a one-clock trough pulse.

Each output group has its own active-level select, and a global enable forces all six phase outputs to their inactive level. A run input starts and freezes the counters. Every rise of the run input starts a fresh carrier from the initial counter values. Duty values are expected to be synchronous to the block clock.

Top module: `cpwm_three_phase`

## Requirements
- R1: The clock edge that first samples `run_i` high loads the leading counter with `dead_i` and the lagging counter with zero. Call this the start edge, count k = 0. Every later edge with `run_i` still high is one counting step. `crest_o` is high exactly in the cycles where k mod (2·`half_i`) equals `half_i`.
- R2: `trough_o` is high exactly in the cycles where k > 0 and k mod (2·`half_i`) = 0. `crest_o` and `trough_o` are each high for one clock only.
- R3: For a duty value d with 0 < d < `half_i`, the positive output becomes active when the lagging counter arrives at d while rising. It becomes inactive when that counter arrives at d while falling. So it is active for k mod 2h in [d, 2h−d), where h = `half_i`.
- R4: For `dead_i` < d < L, where L = `half_i` + `dead_i`, and with u = d − `dead_i`, the inverse output becomes inactive when the leading counter arrives at d while rising. It becomes active when that counter arrives at d while falling. So it is active for k mod 2h ≥ 2h−u, and, from k ≥ 2h onward, also for k mod 2h < u. It starts inactive.
- R5: A counter arriving at its own peak value is not treated as a match. With d = `half_i`, the positive output therefore stays inactive.
- R6: A duty value of zero holds the positive output active and the inverse output inactive, from the start edge onward.
- R7: A duty value at or above L holds the positive output inactive and the inverse output active, from the start edge onward.
- R8: `sync_o` is 1 at the start edge and toggles on every crest and on every trough. It equals 1 when floor(k/h) is even and 0 otherwise.
- R9: Each pin is driven combinationally from its phase state. A positive pin shows `pos_act_hi_i` when active and its complement when inactive. An inverse pin does the same with `neg_act_hi_i`.
- R10: While `out_en_i` is 0, all six phase pins show their inactive level.
- R11: While `run_i` is 0, the counters and the phase states hold, and the crest and trough pulses stay low. A rise of `run_i` restarts the sequence at k = 0, with all phase states inactive before any forcing applies.
- R12: During and after reset, before the first start, every phase state is inactive, `sync_o` is 1, and `crest_o` and `trough_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | High to count; a rising level restarts from the initial values |
| out_en_i | input | 1 | Global enable for the six phase pins |
| dead_i | input | W | Dead-time count |
| half_i | input | W | Half-carrier count |
| duty_i | input | 3·W | Duty compare values, phase p in bits [p·W +: W] |
| pos_act_hi_i | input | 1 | Active level of the positive pins (1 = high) |
| neg_act_hi_i | input | 1 | Active level of the inverse pins (1 = high) |
| pos_o | output | 3 | Positive pins, one per phase |
| neg_o | output | 3 | Inverse pins, one per phase |
| sync_o | output | 1 | Level toggling at every crest and trough |
| crest_o | output | 1 | One-clock pulse at the carrier crest |
| trough_o | output | 1 | One-clock pulse at the carrier trough |

## Verification
Counter-driven results have no extra pipeline stage:
- The phase states are registered on the same edge at which the counter arrives at the compare value.
- The crest and trough flops are registered on the edge at which the counter arrives at its limit.
- `sync_o` is registered on that same edge.

All of these therefore show the value for count k one cycle after the start edge's sample point, that is, in the sample that follows edge k. The enable and polarity selects act combinationally, in the same cycle. The bench applies stimulus at the falling edge. In that same step it queues the expected output of every future cycle, computed from the closed forms above. A monitor compares one queued entry a few nanoseconds after each rising edge, so an entry is never consumed before the edge it describes.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

  typedef enum logic {
    SLOPE_UP = 1'b0,
    SLOPE_DN = 1'b1
  } slope_e;

  // pin level for a phase state under enable and active-level select
  function automatic logic pin_level(logic on, logic en, logic act_hi);
    return (on && en) ? act_hi : ~act_hi;
  endfunction

endpackage

// File: rtl/cpwm_tri_counter.sv
`timescale 1ns/1ps
module cpwm_tri_counter
  import cpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] floor_i,
  input  logic [W-1:0] ceil_i,
  output logic [W-1:0] next_o,
  output logic         rising_o,
  output logic         hit_ceil_o,
  output logic         hit_floor_o
);

  logic [W-1:0] cnt_q, cnt_d, step_val;
  slope_e       dir_q, dir_d;
  logic         cnt_en;

  assign cnt_en = load_i | step_i;

  always_comb begin
    step_val = (dir_q == SLOPE_UP) ? cnt_q + 1'b1 : cnt_q - 1'b1;
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    if (load_i) begin
      cnt_d = floor_i;
      dir_d = SLOPE_UP;
    end else if (step_i) begin
      cnt_d = step_val;
      if (dir_q == SLOPE_UP && step_val == ceil_i) begin
        dir_d = SLOPE_DN;
      end else if (dir_q == SLOPE_DN && step_val == floor_i) begin
        dir_d = SLOPE_UP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= SLOPE_UP;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign next_o      = step_val;
  assign rising_o    = (dir_q == SLOPE_UP);
  assign hit_ceil_o  = step_i && rising_o && (step_val == ceil_i);
  assign hit_floor_o = step_i && !rising_o && (step_val == floor_i);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(cnt_q));

  // R1
  load_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(floor_i)) && rising_o);

endmodule

// File: rtl/cpwm_phase_pair.sv
`timescale 1ns/1ps
module cpwm_phase_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] lead_next_i,
  input  logic         lead_rise_i,
  input  logic         lead_ceil_i,
  input  logic [W-1:0] lag_next_i,
  input  logic         lag_rise_i,
  input  logic         lag_ceil_i,
  output logic         pos_on_o,
  output logic         neg_on_o
);

  logic pos_q, pos_d, neg_q, neg_d;
  logic lag_hit, lead_hit, hold_on, hold_off, st_en;

  assign st_en = load_i | step_i;

  always_comb begin
    lag_hit  = step_i && (lag_next_i == duty_i);
    lead_hit = step_i && (lead_next_i == duty_i);
    hold_on  = (duty_i == '0);
    hold_off = (duty_i >= limit_i);
    pos_d    = pos_q;
    neg_d    = neg_q;
    if (load_i) begin
      pos_d = 1'b0;
      neg_d = 1'b0;
    end else begin
      if (lag_hit && lag_rise_i && !lag_ceil_i) begin
        pos_d = 1'b1;
      end else if (lag_hit && !lag_rise_i) begin
        pos_d = 1'b0;
      end
      if (lead_hit && lead_rise_i && !lead_ceil_i) begin
        neg_d = 1'b0;
      end else if (lead_hit && !lead_rise_i) begin
        neg_d = 1'b1;
      end
    end
    if (st_en) begin
      if (hold_on) begin
        pos_d = 1'b1;
        neg_d = 1'b0;
      end else if (hold_off) begin
        pos_d = 1'b0;
        neg_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (st_en) begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  assign pos_on_o = pos_q;
  assign neg_on_o = neg_q;

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_i || step_i) && duty_i == '0) |=> (pos_on_o && !neg_on_o));

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_i || step_i) && duty_i != '0 && duty_i >= limit_i) |=> (!pos_on_o && neg_on_o));

  // R5
  peak_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && lag_ceil_i && lag_next_i == duty_i && duty_i != '0 && duty_i < limit_i)
      |=> (pos_on_o == $past(pos_on_o)));

endmodule

// File: rtl/cpwm_three_phase.sv
`timescale 1ns/1ps
module cpwm_three_phase
  import cpwm_pkg::*;
#(
  parameter int W   = 16,
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             out_en_i,
  input  logic [W-1:0]     dead_i,
  input  logic [W-1:0]     half_i,
  input  logic [NPH*W-1:0] duty_i,
  input  logic             pos_act_hi_i,
  input  logic             neg_act_hi_i,
  output logic [NPH-1:0]   pos_o,
  output logic [NPH-1:0]   neg_o,
  output logic             sync_o,
  output logic             crest_o,
  output logic             trough_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic run_q, load, step;
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) run_q <= 1'b0;
    else          run_q <= run_i;
  end
  assign load = run_i & ~run_q;
  assign step = run_i & run_q;

  logic [W-1:0] limit;
  assign limit = half_i + dead_i;

  logic [W-1:0] lead_next, lag_next;
  logic lead_rise, lead_ceil, lead_floor;
  logic lag_rise, lag_ceil, lag_floor;

  cpwm_tri_counter #(.W(W)) u_lead (
    .clk(clk), .rst_n(rst_n_q), .load_i(load), .step_i(step),
    .floor_i(dead_i), .ceil_i(limit),
    .next_o(lead_next), .rising_o(lead_rise),
    .hit_ceil_o(lead_ceil), .hit_floor_o(lead_floor)
  );

  cpwm_tri_counter #(.W(W)) u_lag (
    .clk(clk), .rst_n(rst_n_q), .load_i(load), .step_i(step),
    .floor_i('0), .ceil_i(half_i),
    .next_o(lag_next), .rising_o(lag_rise),
    .hit_ceil_o(lag_ceil), .hit_floor_o(lag_floor)
  );

  // carrier markers
  logic sync_q, sync_d, crest_q, crest_d, trough_q, trough_d;

  always_comb begin
    crest_d  = lead_ceil;
    trough_d = lag_floor;
    sync_d   = sync_q;
    if (load) begin
      sync_d = 1'b1;
    end else if (lead_ceil || lag_floor) begin
      sync_d = ~sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      sync_q   <= 1'b1;
      crest_q  <= 1'b0;
      trough_q <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      crest_q  <= crest_d;
      trough_q <= trough_d;
    end
  end

  assign sync_o   = sync_q;
  assign crest_o  = crest_q;
  assign trough_o = trough_q;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic pos_on, neg_on;
    cpwm_phase_pair #(.W(W)) u_pair (
      .clk(clk), .rst_n(rst_n_q), .load_i(load), .step_i(step),
      .duty_i(duty_i[p*W +: W]), .limit_i(limit),
      .lead_next_i(lead_next), .lead_rise_i(lead_rise), .lead_ceil_i(lead_ceil),
      .lag_next_i(lag_next), .lag_rise_i(lag_rise), .lag_ceil_i(lag_ceil),
      .pos_on_o(pos_on), .neg_on_o(neg_on)
    );
    assign pos_o[p] = pin_level(pos_on, out_en_i, pos_act_hi_i);
    assign neg_o[p] = pin_level(neg_on, out_en_i, neg_act_hi_i);
  end

  // R1
  counter_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    step |-> (lead_ceil == lag_ceil) && (lead_floor == lag_floor));

  // R2
  crest_single_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    crest_o |=> !crest_o);

  // R2
  trough_single_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    trough_o |=> !trough_o);

  // R8
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (sync_o != $past(sync_o)) |-> (crest_o || trough_o || $past(load)));

endmodule

// File: tb/tb_cpwm_three_phase.sv
`timescale 1ns/1ps
module tb_cpwm_three_phase;

  localparam int W    = 16;
  localparam int NPH  = 3;
  localparam int DEAD = 3;
  localparam int HALF = 20;
  localparam int LIM  = DEAD + HALF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, run, oen, pah, nah;
  logic [W-1:0]     dead, half;
  logic [NPH*W-1:0] duty;
  logic [NPH-1:0]   pos_o, neg_o;
  logic             sync_o, crest_o, trough_o;

  cpwm_three_phase #(.W(W), .NPH(NPH)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .out_en_i(oen),
    .dead_i(dead), .half_i(half), .duty_i(duty),
    .pos_act_hi_i(pah), .neg_act_hi_i(nah),
    .pos_o(pos_o), .neg_o(neg_o), .sync_o(sync_o),
    .crest_o(crest_o), .trough_o(trough_o)
  );

  typedef struct packed {
    logic [2:0] pos;
    logic [2:0] neg;
    logic       sync;
    logic       crest;
    logic       trough;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  task automatic chk(string tag, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic bit pos_state(int k, int d);
    int t;
    t = k % (2 * HALF);
    if (d == 0) return 1'b1;
    if (d >= LIM || d >= HALF) return 1'b0;
    return (t >= d) && (t < 2 * HALF - d);
  endfunction

  function automatic bit neg_state(int k, int d);
    int t, u;
    t = k % (2 * HALF);
    u = d - DEAD;
    if (d == 0) return 1'b0;
    if (d >= LIM) return 1'b1;
    return (t >= 2 * HALF - u) || (k >= 2 * HALF && t < u);
  endfunction

  function automatic logic pin(bit on, bit en, bit act_hi);
    return (on && en) ? act_hi : ~act_hi;
  endfunction

  function automatic exp_t model(int k, int d0, int d1, int d2, bit ph, bit nh, bit en);
    exp_t e;
    int   d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int i = 0; i < 3; i++) begin
      e.pos[i] = pin(pos_state(k, d[i]), en, ph);
      e.neg[i] = pin(neg_state(k, d[i]), en, nh);
    end
    e.sync   = ((k / HALF) % 2) == 0;
    e.crest  = (k % (2 * HALF)) == HALF;
    e.trough = (k > 0) && ((k % (2 * HALF)) == 0);
    return e;
  endfunction

  // driver: called at a falling edge; queues every expected cycle, then starts
  task automatic run_window(int n, int d0, int d1, int d2, string tp, string tn, string ts);
    duty = {W'(d2), W'(d1), W'(d0)};
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model(k, d0, d1, d2, pah, nah, oen));
      tag_q.push_back(tp); tag_q.push_back(tn); tag_q.push_back(ts);
    end
    run = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic freeze(int n, int k_last, int d0, int d1, int d2);
    exp_t e;
    e = model(k_last, d0, d1, d2, pah, nah, oen);
    e.crest  = 1'b0;
    e.trough = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e);
      tag_q.push_back("R11"); tag_q.push_back("R11"); tag_q.push_back("R11");
    end
    run = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares one entry shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string tp, tn, ts;
        e  = exp_q.pop_front();
        tp = tag_q.pop_front();
        tn = tag_q.pop_front();
        ts = tag_q.pop_front();
        for (int i = 0; i < 3; i++) begin
          chk(tp, $sformatf("pos[%0d]", i), int'(pos_o[i]), int'(e.pos[i]));
          chk(tn, $sformatf("neg[%0d]", i), int'(neg_o[i]), int'(e.neg[i]));
        end
        chk(ts, "sync", int'(sync_o), int'(e.sync));
        chk("R1", "crest", int'(crest_o), int'(e.crest));
        chk("R2", "trough", int'(trough_o), int'(e.trough));
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; oen = 1'b1; pah = 1'b0; nah = 1'b0;
    dead  = W'(DEAD); half = W'(HALF);
    duty  = {W'(10), W'(10), W'(10)};
    repeat (3) @(negedge clk);
    // R12: reset state, active-low pins idle high
    chk("R12", "pos in reset", int'(pos_o), 7);
    chk("R12", "neg in reset", int'(neg_o), 7);
    chk("R12", "sync in reset", int'(sync_o), 1);
    chk("R12", "crest in reset", int'(crest_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "pos after reset", int'(pos_o), 7);
    chk("R12", "neg after reset", int'(neg_o), 7);
    chk("R12", "trough after reset", int'(trough_o), 0);

    // R3 R4 R1 R2 R8: three ordinary duty values
    run_window(100, 10, 5, 16, "R3", "R4", "R8");
    freeze(10, 99, 10, 5, 16);
    // R5 R6 R7 and restart from initial values (R11)
    run_window(60, 0, 20, 23, "R5 R6 R7", "R6 R7", "R11");
    freeze(5, 59, 0, 20, 23);
    // R9: positive active high, inverse active low; R7 with a value above the limit
    pah = 1'b1; nah = 1'b0;
    run_window(60, 30, 12, 7, "R7 R9", "R9", "R8");
    freeze(5, 59, 30, 12, 7);
    // R10: outputs disabled while counting
    oen = 1'b0;
    run_window(45, 10, 10, 10, "R10", "R10", "R8");
    repeat (3) @(negedge clk);
    chk("R1", "queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule